// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Unit

This unit keeps the status byte of a small serial-access nonvolatile memory and decides, cycle by cycle, whether a write is allowed. The serial command engine sends it one-cycle strobes: latch-enable, latch-disable, status-write (with its data byte), and end-of-memory-write. It also passes on the level of the external write-protect pin and the address of the byte about to be written. The unit returns the status byte, which the engine shifts out on a status read. It also returns two permission flags: one for the queried memory address and one for a status write.

The status byte holds six retained configuration bits: a pin-protect enable, three spare bits and a two-bit block-protect code. It also holds a volatile write-enable latch, and its bit 0 is always zero. The retained bits keep their values through a reset pulse and start from a parameter value. Only the latch is cleared by reset. The memory permission depends only on the current state and the current address, so the engine can query every byte of an auto-incrementing burst as it arrives.

Top module: `statguard_top`

## Requirements
- R1: After reset, status bit 1 (latch) reads 0. Bits 7..2 read the parameter NV_INIT, which is 0 by default. Both permission flags read 0.
- R2: A latch-enable strobe sets status bit 1 at the next clock edge. A latch-disable strobe clears it.
- R3: A status-write strobe that is permitted loads data bits 7..2 into status bits 7..2. Data bits 1..0 are ignored. The latch is cleared at the same edge.
- R4: A status-write strobe that is not permitted leaves status bits 7..2 unchanged. It still clears the latch.
- R5: An end-of-memory-write strobe clears the latch.
- R6: Status bit 0 always reads 0. Status bit 7 is the pin-protect enable, bits 6..4 are spare retained bits and bits 3..2 are the block-protect code.
- R7: Block-protect code 00 protects no address. Code 01 protects 0x1800..0x1FFF, code 10 protects 0x1000..0x1FFF and code 11 protects every address.
- R8: While the latch is 0, both permission flags are 0.
- R9: With the latch at 1, the status-write flag is 1 when bit 7 is 0 or when the write-protect pin is high. It is 0 when bit 7 is 1 and the pin is low.
- R10: The memory permission flag equals latch AND NOT protected(address), combinationally on the current address.
- R11: A clearing strobe (latch-disable, status-write or end-of-memory-write) in the same cycle as latch-enable wins, so the latch is cleared.
- R12: A reset pulse clears only the latch. Status bits 7..2 keep the values they held before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the latch only |
| cmd_wren | input | 1 | Latch-enable strobe |
| cmd_wrdi | input | 1 | Latch-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe, completes the command |
| wrsr_data | input | 8 | Data byte for the status write |
| cmd_wr_end | input | 1 | End-of-memory-write strobe |
| wp_pin | input | 1 | External write-protect pin, low means protect |
| query_addr | input | ADDR_W | Address of the memory byte to be written |
| status_byte | output | 8 | Status value for status reads |
| mem_wr_ok | output | 1 | Write permitted at query_addr |
| sr_wr_ok | output | 1 | Status write permitted |

## Verification
A wrong latch shows up one cycle after the strobe in two places. Status bit 1 reads back wrong, and both permission flags flip for every address. A corrupted retained bit is visible in the status byte at the next edge. If the wrong bit is in the block-protect code, it also moves the protected boundary, so the bench probes the addresses on each side of the quarter and half boundaries under every code. A wrong pin gate shows in the same cycle as an error in the status-write flag while the enable bit is set and the pin is low.

// File: rtl/statguard_pkg.sv
package statguard_pkg;
    localparam int NV_W = 6;
    localparam int WPEN_IDX = 5;

    typedef struct packed {
        logic              wel;
        logic [NV_W-1:0]   nv;
    } sg_state_t;
endpackage

// File: rtl/sg_latch.sv
module sg_latch
    import statguard_pkg::*;
#(
    parameter logic [NV_W-1:0] NV_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wren,
    input  logic            cmd_wrdi,
    input  logic            cmd_wrsr,
    input  logic [NV_W-1:0] wrsr_bits,
    input  logic            cmd_wr_end,
    input  logic            sr_allow,
    output logic            wel,
    output logic [NV_W-1:0] nv
);
    sg_state_t       st_d;
    logic            wel_q;
    logic [NV_W-1:0] nv_q = NV_INIT;
    logic            clear_evt;

    always_comb begin
        st_d.wel  = wel_q;
        st_d.nv   = nv_q;
        clear_evt = cmd_wrdi | cmd_wrsr | cmd_wr_end;
        if (cmd_wrsr && sr_allow) begin
            st_d.nv = wrsr_bits;
        end
        if (clear_evt) begin
            st_d.wel = 1'b0;
        end else if (cmd_wren) begin
            st_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        nv_q <= st_d.nv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else begin
            wel_q <= st_d.wel;
        end
    end

    assign wel = wel_q;
    assign nv  = nv_q;

    // R2
    wren_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !cmd_wrdi && !cmd_wrsr && !cmd_wr_end) |=> wel_q);
    // R11
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrdi || cmd_wrsr || cmd_wr_end) |=> !wel_q);
    // R4
    nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wrsr && sr_allow) |=> $stable(nv_q));
endmodule

// File: rtl/sg_range.sv
module sg_range #(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    output logic              prot
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (bp)
            2'b00: prot = 1'b0;
            2'b01: prot = addr[TOP] & addr[TOP-1];
            2'b10: prot = addr[TOP];
            default: prot = 1'b1;
        endcase
    end

    // R7
    always_comb begin
        if (bp != 2'b00 && (&addr)) begin
            top_addr_prot_chk: assert (prot);
        end
    end
endmodule

// File: rtl/sg_policy.sv
module sg_policy (
    input  logic wel,
    input  logic wpen,
    input  logic wp_pin,
    input  logic prot,
    output logic mem_ok,
    output logic sr_ok
);
    always_comb begin
        mem_ok = wel & ~prot;
        sr_ok  = wel & (~wpen | wp_pin);
    end
endmodule

// File: rtl/statguard_top.sv
module statguard_top
    import statguard_pkg::*;
#(
    parameter int              ADDR_W  = 13,
    parameter logic [NV_W-1:0] NV_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_wr_end,
    input  logic              wp_pin,
    input  logic [ADDR_W-1:0] query_addr,
    output logic [7:0]        status_byte,
    output logic              mem_wr_ok,
    output logic              sr_wr_ok
);
    logic            wel;
    logic [NV_W-1:0] nv;
    logic            prot;
    logic            unused_lowbits;

    assign unused_lowbits = ^wrsr_data[1:0];

    sg_latch #(.NV_INIT(NV_INIT)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wren  (cmd_wren),
        .cmd_wrdi  (cmd_wrdi),
        .cmd_wrsr  (cmd_wrsr),
        .wrsr_bits (wrsr_data[7:2]),
        .cmd_wr_end(cmd_wr_end),
        .sr_allow  (sr_wr_ok),
        .wel       (wel),
        .nv        (nv)
    );

    sg_range #(.ADDR_W(ADDR_W)) u_range (
        .addr(query_addr),
        .bp  (nv[1:0]),
        .prot(prot)
    );

    sg_policy u_policy (
        .wel   (wel),
        .wpen  (nv[WPEN_IDX]),
        .wp_pin(wp_pin),
        .prot  (prot),
        .mem_ok(mem_wr_ok),
        .sr_ok (sr_wr_ok)
    );

    assign status_byte = {nv, wel, 1'b0};

    // R8
    latch_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[1] |-> (!mem_wr_ok && !sr_wr_ok));
    // R9
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[7] && !wp_pin) |-> !sr_wr_ok);
    // R3
    wrsr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrsr |=> !status_byte[1]);
endmodule

// File: tb/tb_statguard_top.sv
module tb_statguard_top;
    typedef struct {
        int         due;
        logic [7:0] st;
        logic       m;
        logic       s;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_wr_end = 0;
    logic [7:0]  wrsr_data = '0;
    logic        wp_pin = 1'b1;
    logic [12:0] query_addr = '0;
    logic [7:0]  status_byte;
    logic        mem_wr_ok, sr_wr_ok;

    int    cyc = 0;
    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    item_t sb[$];
    logic       m_wel = 0;
    logic [5:0] m_nv = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    statguard_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_wr_end(cmd_wr_end),
        .wp_pin(wp_pin), .query_addr(query_addr), .status_byte(status_byte),
        .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    function automatic logic prot_of(input logic [1:0] bp, input logic [12:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 13'h1800;
            2'b10:   return a >= 13'h1000;
            default: return 1'b1;
        endcase
    endfunction

    task automatic push_exp(input string tag);
        item_t it;
        it.due = cyc;
        it.st  = {m_nv, m_wel, 1'b0};
        it.m   = m_wel & ~prot_of(m_nv[1:0], query_addr);
        it.s   = m_wel & (~m_nv[5] | wp_pin);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic step(input logic wren, input logic wrdi, input logic wrsr,
                        input logic wend, input logic [7:0] data,
                        input logic wp, input logic [12:0] addr, input string tag);
        logic sr_now;
        @(posedge clk); #1;
        cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr; cmd_wr_end = wend;
        wrsr_data = data; wp_pin = wp; query_addr = addr;
        sr_now = m_wel & (~m_nv[5] | wp);
        if (wrsr && sr_now) m_nv = data[7:2];
        if (wrdi || wrsr || wend) m_wel = 1'b0;
        else if (wren) m_wel = 1'b1;
        @(posedge clk); #1;
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_wr_end = 0;
        push_exp(tag);
    endtask

    task automatic pulse_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        m_wel = 1'b0;
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (status_byte !== it.st || mem_wr_ok !== it.m || sr_wr_ok !== it.s) begin
                n_fail++;
                $display("FAIL %s: got st=%h mem=%b sr=%b expected st=%h mem=%b sr=%b",
                         it.tag, status_byte, mem_wr_ok, sr_wr_ok, it.st, it.m, it.s);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(0,0,0,0,8'h00,1,13'h0000,"R1 reset state");
        step(1,0,0,0,8'h00,1,13'h1FFF,"R2 wren sets latch");
        step(0,1,0,0,8'h00,1,13'h0000,"R2 wrdi clears / R8 flags low");
        step(0,0,0,0,8'h00,1,13'h1234,"R8 latch low blocks");
        step(1,0,0,0,8'h00,1,13'h0000,"R2 wren again");
        step(0,0,1,0,8'hFF,1,13'h0000,"R3 wrsr loads bits 7..2, R6 bit0 zero");
        step(1,0,0,0,8'h00,1,13'h0000,"R7 code 11 protects all");
        step(0,0,0,0,8'h00,0,13'h0000,"R9 pin low blocks status write");
        step(0,0,1,0,8'h00,0,13'h0000,"R4 blocked wrsr keeps bits");
        step(1,0,0,0,8'h00,1,13'h0000,"R9 pin high allows");
        step(0,0,1,0,8'h0B,1,13'h0000,"R3 low data bits ignored");
        step(1,0,0,0,8'h00,0,13'h0FFF,"R9 enable off ignores pin / R7 code 10 below");
        step(0,0,0,0,8'h00,0,13'h1000,"R10 R7 code 10 boundary");
        step(0,0,1,0,8'h04,0,13'h17FF,"R3 set code 01");
        step(1,0,0,0,8'h00,1,13'h17FF,"R10 R7 code 01 below");
        step(0,0,0,0,8'h00,1,13'h1800,"R10 R7 code 01 boundary");
        step(0,0,1,0,8'h00,1,13'h1FFF,"R3 set code 00");
        step(1,0,0,0,8'h00,1,13'h1FFF,"R7 code 00 none");
        step(0,0,0,1,8'h00,1,13'h1FFF,"R5 write end clears latch");
        step(1,1,0,0,8'h00,1,13'h0000,"R11 wren with wrdi");
        step(1,0,0,1,8'h00,1,13'h0000,"R11 wren with write end");
        step(1,0,0,0,8'h00,1,13'h0000,"R2 set before wrsr");
        step(0,0,1,0,8'h9B,1,13'h0000,"R6 spare bits written");
        step(1,0,0,0,8'h00,1,13'h0000,"R2 latch before reset");
        pulse_reset();
        step(0,0,0,0,8'h00,1,13'h0000,"R12 retained bits survive reset");
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule